// File: doc/BRIEF.md
# Three-Phase Duty Waveform Selector

This block turns one signed duty command into three signed per-phase duty values for a brushless motor drive. It works in one of two ways. In the first, it reads a six-step commutation map, choosing the row by the rotor sector. In the second, it reads an angle-indexed waveform table with linear interpolation between breakpoints. Three table shapes are available: trapezoid, sine, and sine with an added third harmonic. The value read from the map or table is called the shape value. Every phase output is the duty multiplied by its shape value, divided by 1000.

A table waveform is used only when all of the following hold:
- a table mode is selected;
- the duty magnitude is above a small deactivation level;
- the direction sign agrees with the duty sign;
- a speed hysteresis relay is on;
- a period-jitter hysteresis relay is off.

In every other case the block falls back to the commutation map. All state advances only on cycles where `step_en` is high. The outputs are registered, so a step's result appears on the cycle after the step.

Top module: `phase_duty_selector`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three phase outputs and `wave_sel` become 0, and both relays turn off.
- R2: Outputs and relay states change only at an edge where `step_en` is high, and the new values are visible in the following cycle. With `step_en` low they hold, whatever the inputs do.
- R3: The speed relay turns on when |speed| ≥ 60 and turns off when |speed| ≤ 50. Between those levels it keeps its state. It is evaluated in the same step that uses it.
- R4: The jitter relay turns on when |per_delta| ≥ 20 and turns off when |per_delta| ≤ 10. Between those levels it keeps its state. It is evaluated in the same step that uses it.
- R5: The table waveform is used only when all of these hold: mode ≠ 0, |duty| > 10, sign(dir) = sign(duty), the speed relay is on, and the jitter relay is off. `wave_sel` is registered as 1 exactly then. Mode 0 always uses the commutation map.
- R6: The sign function gives −1 for negative values, +1 for positive values and 0 for zero. For example, dir = 0 with nonzero duty does not match, and dir = −2 counts as −1.
- R7: In fallback, the sector is first clipped to 0..5. It then picks map entries sector·3+0, +1 and +2 for phases A, B and C. The default map rows (A,B,C) are:
  - sector 0: (1000, −1000, 0)
  - sector 1: (1000, 0, −1000)
  - sector 2: (0, 1000, −1000)
  - sector 3: (−1000, 1000, 0)
  - sector 4: (−1000, 0, 1000)
  - sector 5: (0, −1000, 1000)
- R8: Each phase output equals duty × shape / 1000, with the division truncated toward zero.
- R9: Mode 1 uses a trapezoid table with 7 points at 60° spacing. The values at 0°, 60°, 120°, …, 360° are 1000, 1000, 0, −1000, −1000, 0, 1000.
- R10: Modes 2 and 3 use tables with 37 points at 10° spacing.
  - Mode 2 uses the sine table. For d in 0..180 its value is s(d) = 4000·d·(180−d)/(40500 − d·(180−d)). For d in 180..360 it is s(d) = −s(d−180).
  - Mode 3 uses the third-harmonic table, with value s(d) + s(3d mod 360)/6.
  - All divisions truncate toward zero.
- R11: Between breakpoints lo and hi, with frac° past lo and table step STEP, the shape value is lo + (hi−lo)·frac/STEP, truncated toward zero. Angles above 360 are treated as 360.
- R12: Phase B reads the shape at (angle − 120) mod 360 and phase C reads it at (angle − 240) mod 360, both taken after the clip to 360.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advances relays and output registers this cycle |
| mode | input | 2 | 0 map only, 1 trapezoid, 2 sine, 3 sine with third harmonic |
| duty | input | 16 | Signed duty command |
| dir | input | 2 | Signed rotation direction |
| speed | input | 16 | Signed speed estimate |
| per_delta | input | 16 | Signed change of the commutation period |
| angle | input | 9 | Electrical angle in degrees, 0..511 |
| sector | input | 4 | Signed rotor sector |
| pha_a | output | 16 | Signed phase A duty |
| pha_b | output | 16 | Signed phase B duty |
| pha_c | output | 16 | Signed phase C duty |
| wave_sel | output | 1 | 1 when the last step used the table waveform |

## Verification
The hardest situation to reach from the ports is a relay in its hold band. In that band the result depends on the step history, not on the present input. The stimulus ramps speed and period jitter upward through the band, then past the upper level, back into the band, and through the lower level. It keeps the other gate terms satisfied throughout, so every relay transition shows up at `wave_sel` and in the phase values. Table interpolation is swept in 5° steps over 0..420 and past 360 to 511, in every mode, with positive and negative duty. This exercises truncation of negative products.

// File: rtl/pdw_pkg.sv
// Package for the phase duty selector.
// Holds the shared constants, the sign helper and the builders for the
// default waveform and commutation tables.
// Assumption: the table words are TW bits wide and signed.
package pdw_pkg;
    localparam int TW         = 16;
    localparam int FULL_TURN  = 360;
    localparam int PH_SHIFT   = 120;
    localparam int TRAP_STEP  = 60;
    localparam int SIN_STEP   = 10;
    localparam int TRAP_N     = FULL_TURN / TRAP_STEP + 1;
    localparam int SIN_N      = FULL_TURN / SIN_STEP + 1;
    localparam int SECTORS    = 6;
    localparam int PHASES     = 3;
    localparam int DUTY_SCALE = 1000;

    // Returns the sign of v as -1, 0 or +1.
    function automatic int sgn(int v);
        return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
    endfunction

    // Trapezoid shape at a multiple of 60 degrees.
    function automatic int trap_pt(int d);
        case ((d % FULL_TURN) / TRAP_STEP)
            0, 1:    return 1000;
            3, 4:    return -1000;
            default: return 0;
        endcase
    endfunction

    // Rational sine approximation scaled to 1000.
    function automatic int sine_pt(int d);
        int e, h, v;
        e = d % FULL_TURN;
        h = (e >= 180) ? e - 180 : e;
        v = 4000 * h * (180 - h) / (40500 - h * (180 - h));
        return (e >= 180) ? -v : v;
    endfunction

    // Sine plus a sixth of the third harmonic.
    function automatic int sin3_pt(int d);
        return sine_pt(d) + sine_pt((3 * d) % FULL_TURN) / 6;
    endfunction

    // Builds the trapezoid table, entry i at bits [i*TW +: TW].
    function automatic logic [TRAP_N*TW-1:0] build_trap();
        logic [TRAP_N*TW-1:0] t;
        t = '0;
        for (int i = 0; i < TRAP_N; i++) t[i*TW +: TW] = TW'(trap_pt(i * TRAP_STEP));
        return t;
    endfunction

    // Builds the sine table (h3 = 0) or the third-harmonic table (h3 = 1).
    function automatic logic [SIN_N*TW-1:0] build_sin(bit h3);
        logic [SIN_N*TW-1:0] t;
        t = '0;
        for (int i = 0; i < SIN_N; i++)
            t[i*TW +: TW] = h3 ? TW'(sin3_pt(i * SIN_STEP)) : TW'(sine_pt(i * SIN_STEP));
        return t;
    endfunction

    // Builds the six-step map; entry s*3+p holds phase p in sector s.
    function automatic logic [SECTORS*PHASES*TW-1:0] build_comm();
        logic [SECTORS*PHASES*TW-1:0] t;
        t = '0;
        for (int s = 0; s < SECTORS; s++)
            for (int p = 0; p < PHASES; p++)
                t[(s*PHASES+p)*TW +: TW] =
                    TW'(trap_pt(s * TRAP_STEP - p * PH_SHIFT + FULL_TURN));
        return t;
    endfunction
endpackage

// File: rtl/pdw_relay.sv
// Hysteresis relay on the magnitude of a signed value.
// Turns on at |value| >= HI and off at |value| <= LO. In between it
// holds its state. The state advances only when step_en is high.
// Assumption: LO < HI.
module pdw_relay #(
    parameter int W  = 16,
    parameter int HI = 60,
    parameter int LO = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic signed [W-1:0] value,
    output logic                on_next,
    output logic                on_q
);
    logic signed [W:0] ext;
    logic signed [W:0] mag;

    // Magnitude, one bit wider so that the most negative value fits.
    always_comb begin
        ext = {value[W-1], value};
        mag = ext[W] ? -ext : ext;
    end

    // Next relay state from the thresholds and the present state.
    always_comb begin
        if (int'(mag) >= HI)      on_next = 1'b1;
        else if (int'(mag) <= LO) on_next = 1'b0;
        else                      on_next = on_q;
    end

    // State register, updated once per step.
    always_ff @(posedge clk) begin
        if (!rst_n)       on_q <= 1'b0;
        else if (step_en) on_q <= on_next;
    end
endmodule

// File: rtl/pdw_interp.sv
// Linear interpolation in one periodic waveform table.
// The angle is clipped to the span and shifted back by SHIFT degrees,
// wrapping modulo the span.
// Assumptions: the table's last point equals its first, and
// SHIFT < STEP*(NPTS-1).
module pdw_interp
    import pdw_pkg::*;
#(
    parameter int                  STEP  = 10,
    parameter int                  NPTS  = 37,
    parameter int                  SHIFT = 0,
    parameter int                  AW    = 9,
    parameter logic [NPTS*TW-1:0]  TBL   = '0
) (
    input  logic [AW-1:0]        angle,
    output logic signed [TW-1:0] shape
);
    localparam int SPAN = STEP * (NPTS - 1);

    int x, idx, nxt, frac, lo_v, hi_v;

    // Index, fraction and interpolated value.
    always_comb begin
        x = (int'(angle) > SPAN) ? SPAN : int'(angle);
        x = x - SHIFT;
        if (x < 0) x = x + SPAN;
        idx  = x / STEP;
        frac = x - idx * STEP;
        nxt  = (idx < NPTS - 1) ? idx + 1 : idx;
        lo_v = int'($signed(TBL[idx*TW +: TW]));
        hi_v = int'($signed(TBL[nxt*TW +: TW]));
        shape = TW'(lo_v + (hi_v - lo_v) * frac / STEP);
    end
endmodule

// File: rtl/phase_duty_selector.sv
// Three-phase duty waveform selector.
// Chooses between the six-step map and the interpolated waveform tables,
// scales each shape value by duty/1000 and registers the result on each
// step.
// Assumptions: the synchronous reset is active low, and |duty| stays small
// enough that the scaled result fits in DW bits.
module phase_duty_selector
    import pdw_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 9,
    parameter int SW       = 4,
    parameter int SPD_HI   = 60,
    parameter int SPD_LO   = 50,
    parameter int JIT_HI   = 20,
    parameter int JIT_LO   = 10,
    parameter int DUTY_MIN = 10,
    parameter logic [TRAP_N*TW-1:0]             TRAP_TBL = build_trap(),
    parameter logic [SIN_N*TW-1:0]              SIN_TBL  = build_sin(1'b0),
    parameter logic [SIN_N*TW-1:0]              SIN3_TBL = build_sin(1'b1),
    parameter logic [SECTORS*PHASES*TW-1:0]     COMM_MAP = build_comm()
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [1:0]           mode,
    input  logic signed [DW-1:0] duty,
    input  logic signed [1:0]    dir,
    input  logic signed [DW-1:0] speed,
    input  logic signed [DW-1:0] per_delta,
    input  logic [AW-1:0]        angle,
    input  logic signed [SW-1:0] sector,
    output logic signed [DW-1:0] pha_a,
    output logic signed [DW-1:0] pha_b,
    output logic signed [DW-1:0] pha_c,
    output logic                 wave_sel
);
    localparam int PW = DW + TW;

    logic spd_next, spd_on_q, jit_next, jit_on_q;
    logic allow;
    int   duty_i, duty_abs, sec_c;
    logic signed [DW-1:0] ph_nxt [PHASES];
    logic signed [DW-1:0] ph_q   [PHASES];

    pdw_relay #(.W(DW), .HI(SPD_HI), .LO(SPD_LO)) u_spd (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .value(speed),
        .on_next(spd_next), .on_q(spd_on_q));

    pdw_relay #(.W(DW), .HI(JIT_HI), .LO(JIT_LO)) u_jit (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .value(per_delta),
        .on_next(jit_next), .on_q(jit_on_q));

    // Gate for the table waveform, using this step's relay decisions.
    always_comb begin
        duty_i   = int'(duty);
        duty_abs = (duty_i < 0) ? -duty_i : duty_i;
        allow    = (mode != 2'd0) && (duty_abs > DUTY_MIN) &&
                   (sgn(int'(dir)) == sgn(duty_i)) && spd_next && !jit_next;
    end

    // Sector clipped into the map's range.
    always_comb begin
        sec_c = int'(sector);
        if (sec_c < 0)            sec_c = 0;
        else if (sec_c > SECTORS-1) sec_c = SECTORS - 1;
    end

    for (genvar p = 0; p < PHASES; p++) begin : g_ph
        logic signed [TW-1:0] sh_trap, sh_sin, sh_sin3, sh_comm, sh_sel;
        logic signed [PW-1:0] prod, quot;

        pdw_interp #(.STEP(TRAP_STEP), .NPTS(TRAP_N), .SHIFT(p*PH_SHIFT),
                     .AW(AW), .TBL(TRAP_TBL)) u_trap (.angle(angle), .shape(sh_trap));
        pdw_interp #(.STEP(SIN_STEP), .NPTS(SIN_N), .SHIFT(p*PH_SHIFT),
                     .AW(AW), .TBL(SIN_TBL)) u_sin (.angle(angle), .shape(sh_sin));
        pdw_interp #(.STEP(SIN_STEP), .NPTS(SIN_N), .SHIFT(p*PH_SHIFT),
                     .AW(AW), .TBL(SIN3_TBL)) u_sin3 (.angle(angle), .shape(sh_sin3));

        assign sh_comm = $signed(COMM_MAP[(sec_c*PHASES+p)*TW +: TW]);

        // Shape source: the map in fallback, otherwise the mode's table.
        always_comb begin
            if (!allow)             sh_sel = sh_comm;
            else if (mode == 2'd1)  sh_sel = sh_trap;
            else if (mode == 2'd2)  sh_sel = sh_sin;
            else                    sh_sel = sh_sin3;
        end

        // Scale by duty/1000, with the division truncating toward zero.
        assign prod = PW'(duty) * PW'(sh_sel);
        assign quot = prod / PW'(DUTY_SCALE);
        assign ph_nxt[p] = quot[DW-1:0];
    end

    // Output registers, loaded once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PHASES; p++) ph_q[p] <= '0;
            wave_sel <= 1'b0;
        end else if (step_en) begin
            for (int p = 0; p < PHASES; p++) ph_q[p] <= ph_nxt[p];
            wave_sel <= allow;
        end
    end

    assign pha_a = ph_q[0];
    assign pha_b = ph_q[1];
    assign pha_c = ph_q[2];
endmodule

// File: rtl/pdw_checker.sv
// Property checker for the phase duty selector, bound into the top module.
// It watches the ports and the two relay states.
module pdw_checker #(
    parameter int DW     = 16,
    parameter int SPD_HI = 60,
    parameter int SPD_LO = 50,
    parameter int JIT_HI = 20,
    parameter int JIT_LO = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 step_en,
    input logic [1:0]           mode,
    input logic signed [DW-1:0] duty,
    input logic signed [DW-1:0] speed,
    input logic signed [DW-1:0] per_delta,
    input logic signed [DW-1:0] pha_a,
    input logic signed [DW-1:0] pha_b,
    input logic signed [DW-1:0] pha_c,
    input logic                 wave_sel,
    input logic                 spd_on,
    input logic                 jit_on
);
    int spd_mag, jit_mag;

    // Input magnitudes for the threshold checks.
    always_comb begin
        spd_mag = (int'(speed) < 0) ? -int'(speed) : int'(speed);
        jit_mag = (int'(per_delta) < 0) ? -int'(per_delta) : int'(per_delta);
    end

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(pha_a) && $stable(pha_b) && $stable(pha_c) && $stable(wave_sel)); // R2
    AST_SPD_ON: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && spd_mag >= SPD_HI |=> spd_on); // R3
    AST_SPD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && spd_mag <= SPD_LO |=> !spd_on); // R3
    AST_JIT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && jit_mag >= JIT_HI |=> jit_on); // R4
    AST_JIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && jit_mag <= JIT_LO |=> !jit_on); // R4
    AST_TBL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wave_sel |-> spd_on && !jit_on); // R5
    AST_MODE0_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && mode == 2'd0 |=> !wave_sel); // R5
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && duty == '0 |=> pha_a == '0 && pha_b == '0 && pha_c == '0); // R8
endmodule

bind phase_duty_selector pdw_checker #(
    .DW(DW), .SPD_HI(SPD_HI), .SPD_LO(SPD_LO), .JIT_HI(JIT_HI), .JIT_LO(JIT_LO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .mode(mode), .duty(duty),
    .speed(speed), .per_delta(per_delta), .pha_a(pha_a), .pha_b(pha_b),
    .pha_c(pha_c), .wave_sel(wave_sel), .spd_on(spd_on_q), .jit_on(jit_on_q));

// File: tb/phase_duty_selector_bench.sv
// Bench for phase_duty_selector. A behavioural reference model is
// updated after every rising edge and compared with the outputs at every
// falling edge.
module phase_duty_selector_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 1'b0;
    logic [1:0] mode = '0;
    logic signed [15:0] duty = '0, speed = '0, per_delta = '0;
    logic signed [1:0] dir = '0;
    logic [8:0] angle = '0;
    logic signed [3:0] sector = '0;
    logic signed [15:0] pha_a, pha_b, pha_c;
    logic wave_sel;

    int checks = 0, failures = 0;
    int ea = 0, eb = 0, ec = 0, ew = 0;
    int m_spd = 0, m_jit = 0;

    always #2 clk = ~clk;

    phase_duty_selector u_phase_duty_selector (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .mode(mode), .duty(duty),
        .dir(dir), .speed(speed), .per_delta(per_delta), .angle(angle),
        .sector(sector), .pha_a(pha_a), .pha_b(pha_b), .pha_c(pha_c),
        .wave_sel(wave_sel));

    function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction
    function automatic int isgn(int v); return (v > 0) ? 1 : (v < 0) ? -1 : 0; endfunction

    // R10 sine breakpoint value.
    function automatic int s_pt(int d);
        int e, h, v;
        e = d % 360;
        h = (e >= 180) ? e - 180 : e;
        v = 4000 * h * (180 - h) / (40500 - h * (180 - h));
        return (e >= 180) ? -v : v;
    endfunction

    // Breakpoint value of the mode's waveform (R9, R10).
    function automatic int bp_val(int md, int d);
        int tr[7] = '{1000, 1000, 0, -1000, -1000, 0, 1000};
        if (md == 1) return tr[d / 60];
        if (md == 2) return s_pt(d);
        return s_pt(d) + s_pt((3 * d) % 360) / 6;
    endfunction

    // Interpolated shape value for one phase (R11, R12).
    function automatic int wave(int md, int ang, int ph);
        int x, st, i, f, v0, v1;
        x  = (((ang > 360) ? 360 : ang) - 120 * ph + 720) % 360;
        st = (md == 1) ? 60 : 10;
        i  = x / st;
        f  = x % st;
        v0 = bp_val(md, i * st);
        v1 = bp_val(md, (i + 1) * st);
        return v0 + (v1 - v0) * f / st;
    endfunction

    // Six-step map entry (R7).
    function automatic int comm(int sec, int ph);
        int rows[18] = '{1000, -1000, 0, 1000, 0, -1000, 0, 1000, -1000,
                         -1000, 1000, 0, -1000, 0, 1000, 0, -1000, 1000};
        int s;
        s = (sec < 0) ? 0 : (sec > 5) ? 5 : sec;
        return rows[s * 3 + ph];
    endfunction

    // Reference step: relays, gate, shapes, scaling.
    task automatic model_update();
        int d, sh[3], use_tbl;
        if (!rst_n) begin
            ea = 0; eb = 0; ec = 0; ew = 0; m_spd = 0; m_jit = 0;
            return;
        end
        if (!step_en) return;
        if (iabs(int'(speed)) >= 60) m_spd = 1;
        else if (iabs(int'(speed)) <= 50) m_spd = 0;
        if (iabs(int'(per_delta)) >= 20) m_jit = 1;
        else if (iabs(int'(per_delta)) <= 10) m_jit = 0;
        d = int'(duty);
        use_tbl = (mode != 0) && (iabs(d) > 10) && (isgn(int'(dir)) == isgn(d)) &&
                  (m_spd == 1) && (m_jit == 0);
        for (int p = 0; p < 3; p++)
            sh[p] = use_tbl ? wave(int'(mode), int'(angle), p) : comm(int'(sector), p);
        ea = d * sh[0] / 1000;
        eb = d * sh[1] / 1000;
        ec = d * sh[2] / 1000;
        ew = use_tbl;
    endtask

    // One clock: model after the edge, compare at the falling edge.
    task automatic tick(string tag);
        @(posedge clk);
        #1;
        model_update();
        @(negedge clk);
        checks++;
        if (int'(pha_a) != ea || int'(pha_b) != eb || int'(pha_c) != ec ||
            int'(wave_sel) != ew || $isunknown({pha_a, pha_b, pha_c, wave_sel})) begin
            failures++;
            $display("FAIL %s actual a=%0d b=%0d c=%0d sel=%0d expected a=%0d b=%0d c=%0d sel=%0d",
                     tag, pha_a, pha_b, pha_c, wave_sel, ea, eb, ec, ew);
        end
    endtask

    task automatic drive(int md, int dt, int dr, int sp, int jd, int an, int sc);
        mode = 2'(md); duty = 16'(dt); dir = 2'(dr); speed = 16'(sp);
        per_delta = 16'(jd); angle = 9'(an); sector = 4'(sc);
    endtask

    initial begin
        drive(0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick("R1");
        rst_n = 1'b1; step_en = 1'b1;
        for (int s = -3; s <= 8; s++) begin drive(0, 500, 1, 100, 0, 30, s); tick("R7"); end
        for (int s = 0; s <= 5; s++) begin drive(0, -700, -1, 100, 0, 30, s); tick("R7"); end
        step_en = 1'b0;
        drive(1, 900, 1, 100, 0, 77, 3); tick("R2");
        drive(2, -300, -1, 0, 50, 200, 1); tick("R2"); tick("R2");
        step_en = 1'b1;
        drive(1, 800, 1, 55, 0, 30, 2); tick("R3");
        speed = 16'sd60;  tick("R3");
        speed = 16'sd55;  tick("R3");
        speed = 16'sd50;  tick("R3");
        speed = 16'sd59;  tick("R3");
        speed = -16'sd70; tick("R3");
        speed = -16'sd51; tick("R3");
        speed = 16'sd100; per_delta = 16'sd20; tick("R4");
        per_delta = -16'sd15; tick("R4");
        per_delta = 16'sd11;  tick("R4");
        per_delta = 16'sd10;  tick("R4");
        per_delta = 16'sd19;  tick("R4");
        per_delta = 16'sd0;
        drive(2, 800, -1, 100, 0, 45, 4);  tick("R6");
        drive(2, -800, -1, 100, 0, 45, 4); tick("R6");
        drive(2, 800, 0, 100, 0, 45, 4);   tick("R6");
        drive(2, -500, -2, 100, 0, 45, 4); tick("R6");
        drive(3, 10, 1, 100, 0, 95, 1);    tick("R5");
        drive(3, 11, 1, 100, 0, 95, 1);    tick("R5");
        drive(3, -10, -1, 100, 0, 95, 1);  tick("R5");
        drive(0, 600, 1, 100, 0, 95, 1);   tick("R5");
        drive(2, 0, 0, 100, 0, 95, 1);     tick("R8");
        for (int a = 0; a <= 420; a += 5) begin drive(1, 997, 1, 100, 0, a, 0); tick("R9"); end
        for (int a = 0; a <= 420; a += 5) begin drive(2, 997, 1, 100, 0, a, 0); tick("R10"); end
        for (int a = 0; a <= 420; a += 5) begin drive(3, 997, 1, 100, 0, a, 0); tick("R10"); end
        for (int a = 355; a <= 511; a += 13) begin drive(2, 900, 1, 100, 0, a, 0); tick("R11"); end
        for (int a = 0; a <= 360; a += 7) begin drive(2, -333, -1, 100, 0, a, 0); tick("R8"); end
        for (int a = 0; a <= 240; a += 120) begin drive(3, 1000, 1, 100, 0, a, 0); tick("R12"); end
        rst_n = 1'b0; tick("R1"); rst_n = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule